// File: doc/BRIEF.md
# Rotating-Preset Step-of-Five Counter

This block is a binary counter whose value grows by five on every enabled clock edge, and it does so without an adder in the low bits. The low nibble comes from a first stage with a variable source: three loadable 4-bit down counters with preset values 0, 5 and 10. A modulo-3 selector picks one of them as the low nibble. Each time the selector wraps from its third position back to its first, all three down counters step down by one, modulo 16. The upper bits form a plain binary counter. A 4-bit register keeps the nibble currently on the output, and a magnitude comparator advances the upper counter whenever the incoming nibble is below that stored value.

All state moves on the same enabled edge, so the output is an exact multiple of five at every cycle (modulo the full width). A synchronous active-low reset loads the presets and clears the upper counter. When the enable is low, everything holds.

Top module: `step5_rotary_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next value of `count` is 0, whatever `en` is; reset wins over enable.
- R2: At each rising edge with `rst_n` high and `en` high, `count` becomes its previous value plus 5, modulo 2^(4+UPPER_W).
- R3: At a rising edge with `rst_n` high and `en` low, `count` keeps its value, and the next enabled step continues from it.
- R4: After reset the low nibble `count[3:0]` follows the three presets in selector order: 0x0, 0x5, 0xA on the first three outputs (reset, one step, two steps).
- R5: When the selector goes from its third position back to its first, all three down counters step down by one modulo 16, so the third enabled step after reset shows low nibble 0xF with upper bits 0.
- R6: The upper bits `count[W-1:4]` advance by one exactly on an enabled edge where the new low nibble is smaller than the stored one; for example, 0x0F is followed by 0x14.
- R7: With the default width of 8 bits, the value 0xFF is followed by 0x04, the upper counter wrapping to 0.
- R8: A reset in the middle of a run restores the start state: the next enabled step after it yields 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; loads presets 0/5/10, clears selector, stored nibble and upper bits |
| en | input | 1 | Count enable; high advances by five, low holds all state |
| count | output | 4+UPPER_W | Upper bits joined to the low nibble; a multiple of five modulo 2^(4+UPPER_W) |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge before counting starts. Their `$past` terms then refer only to state that reset has loaded. They also assume that `en` and `rst_n` are stable around the rising edge. The stimulus meets both conditions: it holds reset low for the first two edges, and it changes the inputs only on falling edges. Enable patterns mix long enabled runs with isolated hold cycles and a mid-run reset, so the run crosses the 8-bit wrap more than once.

// File: rtl/step5_pkg.sv
// Package for the step-of-five counter.
// Holds the nibble width, the step size, the number of preset stages, and
// the selector encoding shared by the stage modules. It assumes the nibble
// modulus (16) is coprime with the step and that the stage count times the
// step stays below the nibble modulus.
package step5_pkg;
    localparam int NIB_W      = 4;
    localparam int STEP       = 5;
    localparam int NUM_STAGES = 3;

    typedef logic [NIB_W-1:0] nib_t;

    // Position of the rotating selector: which preset stage drives the nibble
    typedef enum logic [1:0] {
        SEL_A = 2'd0,
        SEL_B = 2'd1,
        SEL_C = 2'd2
    } sel_e;
endpackage

// File: rtl/step5_down_nib.sv
// One loadable 4-bit down counter of the variable first stage.
// It loads PRESET on synchronous reset and steps down by one, wrapping
// modulo 16, on each cycle where dec is high. It assumes dec is only
// raised on an enabled selector wrap.
module step5_down_nib
    import step5_pkg::*;
#(
    parameter int PRESET = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dec,
    output nib_t q
);
    localparam nib_t LOAD_VAL = nib_t'(PRESET);

    // Load the preset on reset, otherwise count down when told
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= LOAD_VAL;
        else if (dec)
            q <= q - nib_t'(1);
    end

    // R5
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> q == nib_t'($past(q) - nib_t'(1)));

    // R3
    dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec |=> $stable(q));
endmodule

// File: rtl/step5_selector.sv
// Modulo-3 selector that rotates through the three preset stages.
// It advances one position per cycle where adv is high and reports, as a
// combinational flag, when the current position is the last one, so that
// the next advance is a wrap. It assumes adv equals the block enable.
module step5_selector
    import step5_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output sel_e sel,
    output logic at_last
);
    sel_e sel_nx;

    // Pick the following position in the rotation
    always_comb begin
        sel_nx = SEL_A;
        unique case (sel)
            SEL_A:   sel_nx = SEL_B;
            SEL_B:   sel_nx = SEL_C;
            SEL_C:   sel_nx = SEL_A;
            default: sel_nx = SEL_A;
        endcase
    end

    // Flag the last position so the down counters know when to step
    always_comb at_last = (sel == SEL_C);

    // Hold or rotate the selector
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= SEL_A;
        else if (adv)
            sel <= sel_nx;
    end

    // R5
    sel_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && sel == SEL_C) |=> sel == SEL_A);

    // R4
    sel_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && sel == SEL_A) |=> sel == SEL_B);

    // R3
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(sel));
endmodule

// File: rtl/step5_carry_latch.sv
// Stored-nibble register and magnitude comparator.
// It keeps the nibble currently shown on the output and raises carry when
// the nibble about to be shown is smaller, meaning the low part wrapped
// past 16. It assumes nib_next is the nibble the first stage presents
// after the same edge that loads it.
module step5_carry_latch
    import step5_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  nib_t nib_now,
    input  nib_t nib_next,
    output nib_t held,
    output logic carry
);
    // Compare the incoming nibble against the stored one
    always_comb carry = upd && (nib_next < held);

    // Capture the incoming nibble on every enabled edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (upd)
            held <= nib_next;
    end

    // R6
    held_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held == nib_now);

    // R6
    carry_only_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> held < $past(held));
endmodule

// File: rtl/step5_upper.sv
// Upper binary counter of the step-of-five counter.
// It clears on reset and advances by one, wrapping modulo 2^WIDTH, on each
// cycle where inc is high. It assumes inc comes from the nibble comparator.
module step5_upper #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [WIDTH-1:0] q
);
    // Clear or advance the upper count
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (inc)
            q <= q + WIDTH'(1);
    end

    // R6
    upper_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> q == WIDTH'($past(q) + WIDTH'(1)));

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(q));
endmodule

// File: rtl/step5_rotary_counter.sv
// Top of the rotating-preset step-of-five counter.
// Three preset down counters (0, 5, 10) feed a selector-driven multiplexer
// for the low nibble; the stored-nibble comparator advances the upper bits.
// Selector, down counters, stored nibble and upper bits all move on the same
// enabled edge, so count is always a multiple of five modulo 2^(4+UPPER_W).
// It assumes rst_n is held low for at least one edge before counting starts.
module step5_rotary_counter
    import step5_pkg::*;
#(
    parameter int UPPER_W = 4,
    localparam int W      = NIB_W + UPPER_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] count
);
    nib_t               stage_q [NUM_STAGES];
    sel_e               sel;
    logic               at_last;
    logic               stage_dec;
    nib_t               nib_now;
    nib_t               nib_next;
    nib_t               held;
    logic               carry;
    logic [UPPER_W-1:0] upper_q;

    // Down counters step only when the selector wraps on an enabled edge
    always_comb stage_dec = en && at_last;

    // One preset down counter per stage, presets spaced by the step size
    for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
        step5_down_nib #(
            .PRESET(gi * STEP)
        ) stage_i (
            .clk  (clk),
            .rst_n(rst_n),
            .dec  (stage_dec),
            .q    (stage_q[gi])
        );
    end

    step5_selector sel_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (en),
        .sel    (sel),
        .at_last(at_last)
    );

    // Route the selected stage to the low nibble
    always_comb begin
        nib_now = stage_q[0];
        unique case (sel)
            SEL_A:   nib_now = stage_q[0];
            SEL_B:   nib_now = stage_q[1];
            SEL_C:   nib_now = stage_q[2];
            default: nib_now = stage_q[0];
        endcase
    end

    // Nibble shown after the next enabled edge; a wrap also decrements stage A
    always_comb begin
        nib_next = stage_q[1];
        unique case (sel)
            SEL_A:   nib_next = stage_q[1];
            SEL_B:   nib_next = stage_q[2];
            SEL_C:   nib_next = stage_q[0] - nib_t'(1);
            default: nib_next = stage_q[1];
        endcase
    end

    step5_carry_latch cmp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (en),
        .nib_now (nib_now),
        .nib_next(nib_next),
        .held    (held),
        .carry   (carry)
    );

    step5_upper #(
        .WIDTH(UPPER_W)
    ) upper_i (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (carry),
        .q    (upper_q)
    );

    // Join the upper bits to the low nibble
    always_comb count = {upper_q, nib_now};

    // R2
    step_by_five_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> count == W'($past(count) + W'(STEP)));

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));

    // R5
    stage_b_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q[1] == nib_t'(stage_q[0] + nib_t'(STEP)));

    // R5
    stage_c_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q[2] == nib_t'(stage_q[0] + nib_t'(2 * STEP)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> count == '0);
endmodule

// File: tb/step5_rotary_counter_tb_top.sv
module step5_rotary_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int UPPER_W    = 4;
    localparam int W          = 4 + UPPER_W;
    localparam int WATCHDOG   = 200000;

    typedef struct {
        logic [W-1:0] val;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] count;

    int           checks = 0;
    int           errors = 0;
    logic [W-1:0] model = '0;
    exp_t         sb_q[$];
    bit           done = 1'b0;

    step5_rotary_counter #(.UPPER_W(UPPER_W)) dut_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .count(count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Driver: apply inputs on the falling edge, push the expected value after the rising edge
    task automatic drive(input logic r, input logic e, input string tag);
        exp_t it;
        @(negedge clk);
        rst_n = r;
        en    = e;
        @(posedge clk);
        if (!r)
            model = '0;
        else if (e)
            model = W'(model + W'(5));
        it.val = model;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare each expected item once the output has settled
    always @(posedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            checks++;
            if (count !== it.val) begin
                errors++;
                $display("FAIL %s count=0x%0h expected=0x%0h", it.tag, count, it.val);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset clears, including with enable high
        drive(1'b0, 1'b0, "R1");
        drive(1'b0, 1'b1, "R1");
        // R4: nibble shows presets 5 then 10 after 0
        drive(1'b1, 1'b1, "R4");
        drive(1'b1, 1'b1, "R4");
        // R5: wrap decrements stage A, giving 0x0F
        drive(1'b1, 1'b1, "R5");
        // R6: nibble drop 0xF -> 0x4 carries, 0x14
        drive(1'b1, 1'b1, "R6");
        // R3: holds across idle cycles, then continues
        drive(1'b1, 1'b0, "R3");
        drive(1'b1, 1'b0, "R3");
        drive(1'b1, 1'b1, "R3");
        // R2 / R7: long run with sparse idle cycles, crossing the 8-bit wrap
        for (int i = 0; i < 240; i++) begin
            logic e;
            e = (i % 7) != 3;
            if (e && model == W'(8'hFF))
                drive(1'b1, e, "R7");
            else if (e)
                drive(1'b1, e, "R2");
            else
                drive(1'b1, e, "R3");
        end
        // R8: reset mid-run with enable high, then first step yields 5
        drive(1'b0, 1'b1, "R8");
        drive(1'b1, 1'b1, "R8");
        // R7: explicit walk to 0xFF and past it
        for (int i = 0; i < 60; i++) begin
            if (model == W'(8'hFF))
                drive(1'b1, 1'b1, "R7");
            else
                drive(1'b1, 1'b1, "R2");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule